// File: doc/BRIEF.md
# Masked Device Interrupt Controller

This block keeps an interrupt request flag and an interrupt enable flag for each of 256 device numbers. Devices raise and drop their own requests through set and clear strobes that carry a device number. A command byte sent to a device can turn its enable on, turn it off or invert it. A cleared enable only hides a request; the request stays recorded and shows up as soon as the enable returns.

From the pending and enabled requests the block finds the lowest-numbered device and presents its number. It raises the interrupt line to the processor only while the external-interrupt enable bit of the processor status word is set. When that line is up and the status word shows the processor idling, a wake output tells the processor to leave its wait state. Two constant outputs give the memory locations where the old status word is saved and where the new one is fetched for an external interrupt. The status-word swap itself, instruction fetch and device data transfer belong to other blocks.

Top module: `dev_irq_ctrl`

## Requirements
- R1: After reset every request and enable flag is clear, so `irq_o`, `wake_o` and `ack_dev_o` are 0 whatever `psw_i` holds.
- R2: A set strobe for device 1..255 records that device's request in the cycle after the strobe; a set strobe for device 0 records nothing.
- R3: A clear strobe removes that device's request in the cycle after the strobe. When a clear and a set name the same device in one cycle, the clear is applied first, so the request ends up set.
- R4: A command strobe applies bits 7:6 of `cmd_byte_i` to the named device's enable: 1 sets it, 2 clears it, 3 inverts it, 0 leaves it unchanged. Bits 5:0 have no effect on this block.
- R5: A request raised or held while its enable is clear stays recorded and becomes pending as soon as the enable is set, with no new set strobe.
- R6: `irq_o` is 1 exactly when some device has both its request and its enable set and bit 14 (mask 0x4000) of `psw_i` is 1.
- R7: `ack_dev_o` gives the lowest device number whose request and enable are both set, independent of `psw_i`; it is 0 when there is none. Nothing but a clear strobe removes a request, so the same number stays presented until it is cleared or disabled.
- R8: `wake_o` is 1 exactly when `irq_o` is 1 and bit 15 (mask 0x8000, idle) of `psw_i` is 1.
- R9: `old_psw_addr_o` is always 0x40 and `new_psw_addr_o` is always 0x44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_vld_i | input | 1 | Request set strobe |
| set_dev_i | input | 8 | Device number for the set strobe |
| clr_vld_i | input | 1 | Request clear strobe |
| clr_dev_i | input | 8 | Device number for the clear strobe |
| cmd_vld_i | input | 1 | Device command strobe |
| cmd_dev_i | input | 8 | Device number for the command |
| cmd_byte_i | input | 8 | Command byte; bits 7:6 drive the enable |
| psw_i | input | 16 | Processor status word |
| irq_o | output | 1 | External interrupt request to the processor |
| ack_dev_o | output | 8 | Device number to service |
| wake_o | output | 1 | Leave the idle state |
| old_psw_addr_o | output | 8 | Save location of the old status word |
| new_psw_addr_o | output | 8 | Fetch location of the new status word |

## Verification
The hardest situations to reach from the ports are three strobes aimed at the same device in one cycle and a latched request that sits masked and then reappears when only the enable changes. Random stimulus draws device numbers from a small pool of eight values for most cycles, so same-device collisions, toggles of a latched request and lowest-number contests between neighbouring words occur often. Directed sequences add a request on device 255 against device 1, the device-0 set, and status words with the enable and idle bits in every combination.

// File: rtl/dev_irq_pkg.sv
package dev_irq_pkg;
  localparam int unsigned PSW_W      = 16;
  localparam int unsigned PSW_EXT_EN = 14;
  localparam int unsigned PSW_IDLE   = 15;
  localparam logic [7:0]  EXT_OLD_ADDR = 8'h40;
  localparam logic [7:0]  EXT_NEW_ADDR = 8'h44;

  typedef enum logic [1:0] {
    ENB_KEEP = 2'd0,
    ENB_ON   = 2'd1,
    ENB_OFF  = 2'd2,
    ENB_FLIP = 2'd3
  } enb_op_e;
endpackage

// File: rtl/irq_flag_word.sv
module irq_flag_word #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WSEL_W = 3,
  parameter int unsigned WIDX   = 0,
  localparam int unsigned BIT_W = $clog2(WORD_W),
  localparam int unsigned DEV_W = WSEL_W + BIT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_vld_i,
  input  logic [DEV_W-1:0]     set_dev_i,
  input  logic                 clr_vld_i,
  input  logic [DEV_W-1:0]     clr_dev_i,
  input  logic                 cmd_vld_i,
  input  logic [DEV_W-1:0]     cmd_dev_i,
  input  dev_irq_pkg::enb_op_e cmd_op_i,
  output logic [WORD_W-1:0]    req_o,
  output logic [WORD_W-1:0]    enb_o
);
  import dev_irq_pkg::*;
  localparam logic [WSEL_W-1:0] MY_SEL = WSEL_W'(WIDX);

  logic [WORD_W-1:0] set_m, clr_m, cmd_m, req_d, enb_d;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    cmd_m = '0;
    if (set_vld_i && set_dev_i[DEV_W-1:BIT_W] == MY_SEL) set_m[set_dev_i[BIT_W-1:0]] = 1'b1;
    if (clr_vld_i && clr_dev_i[DEV_W-1:BIT_W] == MY_SEL) clr_m[clr_dev_i[BIT_W-1:0]] = 1'b1;
    if (cmd_vld_i && cmd_dev_i[DEV_W-1:BIT_W] == MY_SEL) cmd_m[cmd_dev_i[BIT_W-1:0]] = 1'b1;
  end

  // clear before set: a same-cycle set wins
  assign req_d = (req_o & ~clr_m) | set_m;

  always_comb begin
    unique case (cmd_op_i)
      ENB_ON:   enb_d = enb_o | cmd_m;
      ENB_OFF:  enb_d = enb_o & ~cmd_m;
      ENB_FLIP: enb_d = enb_o ^ cmd_m;
      default:  enb_d = enb_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= '0;
      enb_o <= '0;
    end else begin
      req_o <= req_d;
      enb_o <= enb_d;
    end
  end
endmodule

// File: rtl/irq_word_prio.sv
module irq_word_prio #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] vec_i,
  output logic              any_o,
  output logic [BIT_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = BIT_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_sel_tree.sv
module irq_sel_tree #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned BIT_W     = 5,
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS)
) (
  input  logic [NUM_WORDS-1:0] any_i,
  input  logic [BIT_W-1:0]     idx_i [NUM_WORDS],
  output logic                 any_o,
  output logic [WSEL_W+BIT_W-1:0] dev_o
);
  logic [WSEL_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int w = NUM_WORDS - 1; w >= 0; w--) begin
      if (any_i[w]) sel = WSEL_W'(w);
    end
  end

  assign any_o = |any_i;
  assign dev_o = any_o ? {sel, idx_i[sel]} : '0;
endmodule

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl #(
  parameter int unsigned NUM_DEV = 256,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned DEV_W     = $clog2(NUM_DEV),
  localparam int unsigned BIT_W     = $clog2(WORD_W),
  localparam int unsigned NUM_WORDS = NUM_DEV / WORD_W,
  localparam int unsigned WSEL_W    = DEV_W - BIT_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           set_vld_i,
  input  logic [DEV_W-1:0]               set_dev_i,
  input  logic                           clr_vld_i,
  input  logic [DEV_W-1:0]               clr_dev_i,
  input  logic                           cmd_vld_i,
  input  logic [DEV_W-1:0]               cmd_dev_i,
  input  logic [7:0]                     cmd_byte_i,
  input  logic [dev_irq_pkg::PSW_W-1:0]  psw_i,
  output logic                           irq_o,
  output logic [DEV_W-1:0]               ack_dev_o,
  output logic                           wake_o,
  output logic [7:0]                     old_psw_addr_o,
  output logic [7:0]                     new_psw_addr_o
);
  import dev_irq_pkg::*;

  logic                set_ok;
  enb_op_e             cmd_op;
  logic [NUM_DEV-1:0]  req_flat, enb_flat;
  logic [NUM_WORDS-1:0] word_any;
  logic [BIT_W-1:0]    word_idx [NUM_WORDS];
  logic                pend_any;
  logic                unused_bits;

  // device 0 cannot raise an interrupt
  assign set_ok = set_vld_i && (set_dev_i != '0);
  assign cmd_op = enb_op_e'(cmd_byte_i[7:6]);
  assign unused_bits = ^{cmd_byte_i[5:0], psw_i[PSW_W-3:0]};

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] req_w, enb_w;

    irq_flag_word #(.WORD_W(WORD_W), .WSEL_W(WSEL_W), .WIDX(w)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_vld_i (set_ok),
      .set_dev_i (set_dev_i),
      .clr_vld_i (clr_vld_i),
      .clr_dev_i (clr_dev_i),
      .cmd_vld_i (cmd_vld_i),
      .cmd_dev_i (cmd_dev_i),
      .cmd_op_i  (cmd_op),
      .req_o     (req_w),
      .enb_o     (enb_w)
    );

    irq_word_prio #(.WORD_W(WORD_W)) u_prio (
      .vec_i (req_w & enb_w),
      .any_o (word_any[w]),
      .idx_o (word_idx[w])
    );

    assign req_flat[w*WORD_W +: WORD_W] = req_w;
    assign enb_flat[w*WORD_W +: WORD_W] = enb_w;
  end

  irq_sel_tree #(.NUM_WORDS(NUM_WORDS), .BIT_W(BIT_W)) u_sel (
    .any_i (word_any),
    .idx_i (word_idx),
    .any_o (pend_any),
    .dev_o (ack_dev_o)
  );

  assign irq_o          = pend_any && psw_i[PSW_EXT_EN];
  assign wake_o         = irq_o && psw_i[PSW_IDLE];
  assign old_psw_addr_o = EXT_OLD_ADDR;
  assign new_psw_addr_o = EXT_NEW_ADDR;
endmodule

// File: rtl/dev_irq_ctrl_chk.sv
module dev_irq_ctrl_chk #(
  parameter int unsigned NUM_DEV = 256,
  parameter int unsigned DEV_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               set_vld_i,
  input logic [DEV_W-1:0]   set_dev_i,
  input logic               clr_vld_i,
  input logic [DEV_W-1:0]   clr_dev_i,
  input logic               cmd_vld_i,
  input logic [DEV_W-1:0]   cmd_dev_i,
  input logic [7:0]         cmd_byte_i,
  input logic [15:0]        psw_i,
  input logic               irq_o,
  input logic [DEV_W-1:0]   ack_dev_o,
  input logic               wake_o,
  input logic [NUM_DEV-1:0] req_flat,
  input logic [NUM_DEV-1:0] enb_flat
);
  logic [NUM_DEV-1:0] pend, below;
  assign pend  = req_flat & enb_flat;
  assign below = (NUM_DEV'(1) << ack_dev_o) - NUM_DEV'(1);

  a_r1_dev0_never_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_flat[0]);

  a_r2_set_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_i && set_dev_i != '0 |=> req_flat[$past(set_dev_i)]);

  a_r3_clear_removes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vld_i && !(set_vld_i && set_dev_i == clr_dev_i) |=> !req_flat[$past(clr_dev_i)]);

  a_r4_keep_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i && cmd_byte_i[7:6] == 2'd0 |=> enb_flat == $past(enb_flat));

  a_r4_flip_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i && cmd_byte_i[7:6] == 2'd3 |=> enb_flat[$past(cmd_dev_i)] != $past(enb_flat[cmd_dev_i]));

  a_r6_irq_needs_ext_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> psw_i[14] && pend[ack_dev_o]);

  a_r7_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & below) == '0);

  a_r7_none_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend == '0 |-> ack_dev_o == '0 && !irq_o);

  a_r8_wake_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o && psw_i[15]);
endmodule

bind dev_irq_ctrl dev_irq_ctrl_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .set_vld_i  (set_vld_i),
  .set_dev_i  (set_dev_i),
  .clr_vld_i  (clr_vld_i),
  .clr_dev_i  (clr_dev_i),
  .cmd_vld_i  (cmd_vld_i),
  .cmd_dev_i  (cmd_dev_i),
  .cmd_byte_i (cmd_byte_i),
  .psw_i      (psw_i),
  .irq_o      (irq_o),
  .ack_dev_o  (ack_dev_o),
  .wake_o     (wake_o),
  .req_flat   (req_flat),
  .enb_flat   (enb_flat)
);

// File: tb/dev_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dev_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_vld_i = 1'b0, clr_vld_i = 1'b0, cmd_vld_i = 1'b0;
  logic [7:0]  set_dev_i = '0, clr_dev_i = '0, cmd_dev_i = '0, cmd_byte_i = '0;
  logic [15:0] psw_i = '0;
  logic        irq_o, wake_o;
  logic [7:0]  ack_dev_o, old_psw_addr_o, new_psw_addr_o;

  dev_irq_ctrl u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [255:0] m_req = '0, m_enb = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_ack(input logic [255:0] r, input logic [255:0] e);
    logic [255:0] p = r & e;
    for (int i = 255; i >= 0; i--) if (p[i]) exp_ack = {1'b1, 8'(i)};
    if (p == '0) exp_ack = '0;
  endfunction

  // model update for the strobes currently driven
  task automatic model_edge();
    if (clr_vld_i) m_req[clr_dev_i] = 1'b0;
    if (set_vld_i && set_dev_i != 0) m_req[set_dev_i] = 1'b1;
    if (cmd_vld_i) begin
      case (cmd_byte_i[7:6])
        2'd1: m_enb[cmd_dev_i] = 1'b1;
        2'd2: m_enb[cmd_dev_i] = 1'b0;
        2'd3: m_enb[cmd_dev_i] = ~m_enb[cmd_dev_i];
        default: ;
      endcase
    end
  endtask

  task automatic check_all(input string tag);
    logic [8:0] a = exp_ack(m_req, m_enb);
    logic e_irq = a[8] && psw_i[14];
    chk(ack_dev_o == a[7:0], {tag, " R7 ack"}, 32'(ack_dev_o), 32'(a[7:0]));
    chk(irq_o == e_irq, {tag, " R6 irq"}, 32'(irq_o), 32'(e_irq));
    chk(wake_o == (e_irq && psw_i[15]), {tag, " R8 wake"}, 32'(wake_o), 32'(e_irq && psw_i[15]));
  endtask

  // drive at negedge, commit at posedge, release strobes at next negedge
  task automatic step(input bit sv, input logic [7:0] sd, input bit cv, input logic [7:0] cd,
                      input bit mv, input logic [7:0] md, input logic [7:0] mb);
    @(negedge clk_i);
    set_vld_i = sv; set_dev_i = sd; clr_vld_i = cv; clr_dev_i = cd;
    cmd_vld_i = mv; cmd_dev_i = md; cmd_byte_i = mb;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    set_vld_i = 0; clr_vld_i = 0; cmd_vld_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    psw_i = 16'hC000;
    repeat (3) @(negedge clk_i);
    check_all("R1 in reset");
    chk(irq_o == 0, "R1 irq in reset", 32'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after reset");
    chk(old_psw_addr_o == 8'h40, "R9 old addr", 32'(old_psw_addr_o), 32'h40);
    chk(new_psw_addr_o == 8'h44, "R9 new addr", 32'(new_psw_addr_o), 32'h44);

    // R2: device 0 ignored even when enabled
    step(0, 0, 0, 0, 1, 8'h00, 8'h40);
    step(1, 8'h00, 0, 0, 0, 0, 0);
    chk(ack_dev_o == 0 && irq_o == 0, "R2 device 0 set ignored", 32'(irq_o), 0);

    // R5: masked request latches, appears on enable
    step(1, 8'h25, 0, 0, 0, 0, 0);
    chk(irq_o == 0, "R5 masked request hidden", 32'(irq_o), 0);
    step(0, 0, 0, 0, 1, 8'h25, 8'h7F);
    chk(irq_o == 1 && ack_dev_o == 8'h25, "R5 latched request visible", 32'(ack_dev_o), 32'h25);

    // R4: low bits and keep code do nothing; off, flip
    step(0, 0, 0, 0, 1, 8'h25, 8'h3F);
    chk(ack_dev_o == 8'h25, "R4 keep code", 32'(ack_dev_o), 32'h25);
    step(0, 0, 0, 0, 1, 8'h25, 8'hC0);
    chk(irq_o == 0, "R4 flip to off", 32'(irq_o), 0);
    step(0, 0, 0, 0, 1, 8'h25, 8'hC0);
    chk(ack_dev_o == 8'h25, "R4 flip to on", 32'(ack_dev_o), 32'h25);
    step(0, 0, 0, 0, 1, 8'h25, 8'h80);
    chk(irq_o == 0, "R4 off code", 32'(irq_o), 0);

    // R7: 255 vs 1 lowest wins; request persists until cleared
    step(1, 8'hFF, 0, 0, 1, 8'hFF, 8'h40);
    chk(ack_dev_o == 8'hFF, "R7 device 255 alone", 32'(ack_dev_o), 32'hFF);
    step(1, 8'h01, 0, 0, 1, 8'h01, 8'h40);
    chk(ack_dev_o == 8'h01, "R7 lowest wins", 32'(ack_dev_o), 32'h01);
    repeat (3) @(negedge clk_i);
    chk(ack_dev_o == 8'h01, "R7 request held without clear", 32'(ack_dev_o), 32'h01);

    // R3: clear and set same device, same cycle -> set wins
    step(1, 8'h01, 1, 8'h01, 0, 0, 0);
    chk(ack_dev_o == 8'h01, "R3 set wins over clear", 32'(ack_dev_o), 32'h01);
    step(0, 0, 1, 8'h01, 0, 0, 0);
    chk(ack_dev_o == 8'hFF, "R3 clear removes", 32'(ack_dev_o), 32'hFF);

    // R6/R8: status word combinations
    psw_i = 16'h8000; #1;
    chk(irq_o == 0 && wake_o == 0, "R6 ext enable off", 32'(irq_o), 0);
    psw_i = 16'h4000; #1;
    chk(irq_o == 1 && wake_o == 0, "R8 not idle", 32'(wake_o), 0);
    psw_i = 16'hC000; #1;
    chk(wake_o == 1, "R8 idle wake", 32'(wake_o), 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] pool;
      bit narrow = ($urandom % 4) != 0;
      @(negedge clk_i);
      check_all("random");
      psw_i = 16'($urandom);
      pool = 8'($urandom % 8) * 8'd31;
      set_vld_i = ($urandom % 3) == 0;
      set_dev_i = narrow ? pool : 8'($urandom);
      clr_vld_i = ($urandom % 3) == 0;
      clr_dev_i = narrow ? 8'($urandom % 8) * 8'd31 : 8'($urandom);
      cmd_vld_i = ($urandom % 2) == 0;
      cmd_dev_i = narrow ? (($urandom % 2) ? pool : 8'($urandom % 8) * 8'd31) : 8'($urandom);
      cmd_byte_i = 8'($urandom);
      @(posedge clk_i);
      model_edge();
    end
    @(negedge clk_i);
    check_all("random end");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule